// File: doc/BRIEF.md
# SPI Flash Command Engine

This block lets software run one complete flash-style command on a single-lane SPI bus through a small byte-wide register window. Software first sets three registers: the command byte, how many bytes to send after it, and how many bytes to read back. It then fills a shared data buffer with the bytes to send and sets the start bit. The engine pulls chip select low and shifts out the command byte, then the send bytes from the start of the buffer. It then clocks in the requested number of reply bytes and writes them into the same buffer, directly after the bytes that were sent.

A status word shows whether a command is in progress, how many bytes have finished, and where the engine currently reads and writes in the buffer. A start request whose send and reply lengths together would not fit in the buffer is refused. While a command runs, the command, length and buffer registers are locked.

Top module: `spi_cmd_engine`

## Requirements
- R1: The register window is byte addressed. The command byte is at 0x45, the send length at 0x48 and the reply length at 0x4B, and all three read back the value written. The shared buffer occupies 0x80 to 0xC6 (71 bytes, index = offset - 0x80) and reads back what was written. The trigger offset 0x47, unused offsets and 0xC7 read as 0x00.
- R2: A write to 0x47 with bit 7 set starts a transaction. A write to 0x47 with bit 7 clear starts nothing.
- R3: During a transaction, chip select stays low from the first bit of the command byte to the last bit of the last reply byte. The engine sends the command byte first, then the send-length bytes from buffer index 0 upward, then 0x00 on MOSI for every reply byte. The bus uses SPI mode 0 with the most significant bit first, and a transaction produces exactly 8*(1+send+reply) rising clock edges.
- R4: Each reply byte k (counting from 0) is stored at buffer index send+k. All other buffer positions keep their contents.
- R5: Status bit 31 (byte 0x4F, bit 7) reads 1 from the clock after an accepted trigger until the transaction completes, and reads 0 afterwards.
- R6: The status word is little-endian at 0x4C to 0x4F, and unused bits read 0. Bits 7:0 give the number of finished bytes, counting the command byte. Bits 14:8 give the next buffer index for reply storage. Bits 22:16 give the next buffer index to fetch for sending. An accepted trigger sets these fields to 0, send and 0. After the transaction they read 1+send+reply, send+reply and send. All fields read 0 after reset.
- R7: If send+reply is greater than 71, a trigger is refused: no transaction starts, busy stays 0, chip select stays high and the status fields keep their values. A sum of exactly 71 is accepted.
- R8: While busy, writes to the command, length and buffer registers are ignored, and a second trigger is ignored.
- R9: SCLK idles low while chip select is high. Its period is CLK_DIV system clocks, so chip select stays low for 8*CLK_DIV*(1+send+reply) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The engine is run with a reply-only command, with a mixed command that has both send and reply bytes, and with a command of exactly buffer size. The mixed command separates a correct reply offset from storage at index 0, and shows whether send bytes leak into the reply phase. The full-size command catches an off-by-one in the length limit and in the last buffer position. A trigger with bit 7 clear, an oversized request, and register and trigger writes made while busy show whether the engine ignores what it must ignore; these effects are seen at the bus and through read-back.

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine #(
  parameter int CLK_DIV   = 4,
  parameter int BUF_DEPTH = 71
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       spi_sclk,
  output logic       spi_cs_n,
  output logic       spi_mosi,
  input  logic       spi_miso
);
  localparam int HALF = CLK_DIV / 2;
  localparam int DIVW = $clog2(HALF + 1);
  localparam logic [7:0] A_OP   = 8'h45;
  localparam logic [7:0] A_TRIG = 8'h47;
  localparam logic [7:0] A_TXC  = 8'h48;
  localparam logic [7:0] A_RXC  = 8'h4B;
  localparam logic [7:0] A_STAT = 8'h4C;
  localparam logic [7:0] A_BUF  = 8'h80;

  logic [7:0] mem [0:BUF_DEPTH-1];
  logic [7:0] op_q, txc_q, rxc_q, done_q;
  logic [6:0] rd_ptr, wr_ptr;
  logic       busy, cs_n_q, sclk_q;
  logic [DIVW-1:0] div_cnt;
  logic [2:0] bit_cnt;
  logic [7:0] tx_sh, rx_sh;
  logic [8:0] bidx;

  logic [7:0]  boff;
  logic        in_buf;
  logic [8:0]  total;
  logic        fits, trig, tick, byte_end, cur_rx, last_byte, next_tx;
  logic [31:0] status;

  assign boff      = reg_addr - A_BUF;
  assign in_buf    = (reg_addr >= A_BUF) && (boff < 8'(BUF_DEPTH));
  assign total     = {1'b0, txc_q} + {1'b0, rxc_q};
  assign fits      = total <= 9'(BUF_DEPTH);
  assign trig      = !busy && reg_we && (reg_addr == A_TRIG) && reg_wdata[7];
  assign tick      = busy && (div_cnt == DIVW'(HALF - 1));
  assign byte_end  = tick && sclk_q && (bit_cnt == 3'd7);
  assign cur_rx    = bidx > {1'b0, txc_q};
  assign last_byte = bidx == total;
  assign next_tx   = (bidx + 9'd1) <= {1'b0, txc_q};
  assign status    = {busy, 8'h00, rd_ptr, 1'b0, wr_ptr, done_q};

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_n_q;
  assign spi_mosi = tx_sh[7] & ~cs_n_q;

  always_ff @(posedge clk) begin
    if (!busy && reg_we && in_buf)
      mem[boff[6:0]] <= reg_wdata;
    else if (byte_end && cur_rx)
      mem[wr_ptr] <= rx_sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= '0;
      txc_q   <= '0;
      rxc_q   <= '0;
      done_q  <= '0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      busy    <= 1'b0;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      bidx    <= '0;
    end else if (!busy) begin
      if (reg_we) begin
        case (reg_addr)
          A_OP:    op_q  <= reg_wdata;
          A_TXC:   txc_q <= reg_wdata;
          A_RXC:   rxc_q <= reg_wdata;
          default: ;
        endcase
      end
      if (trig && fits) begin
        busy    <= 1'b1;
        cs_n_q  <= 1'b0;
        sclk_q  <= 1'b0;
        div_cnt <= '0;
        bit_cnt <= '0;
        tx_sh   <= op_q;
        bidx    <= '0;
        done_q  <= '0;
        rd_ptr  <= '0;
        wr_ptr  <= txc_q[6:0];
      end
    end else if (tick) begin
      div_cnt <= '0;
      sclk_q  <= ~sclk_q;
      if (!sclk_q) begin
        rx_sh <= {rx_sh[6:0], spi_miso};
      end else if (bit_cnt != 3'd7) begin
        bit_cnt <= bit_cnt + 3'd1;
        tx_sh   <= {tx_sh[6:0], 1'b0};
      end else begin
        bit_cnt <= '0;
        done_q  <= done_q + 8'd1;
        if (cur_rx) wr_ptr <= wr_ptr + 7'd1;
        if (last_byte) begin
          busy   <= 1'b0;
          cs_n_q <= 1'b1;
          tx_sh  <= '0;
        end else begin
          bidx <= bidx + 9'd1;
          if (next_tx) begin
            tx_sh  <= mem[rd_ptr];
            rd_ptr <= rd_ptr + 7'd1;
          end else begin
            tx_sh <= 8'h00;
          end
        end
      end
    end else begin
      div_cnt <= div_cnt + DIVW'(1);
    end
  end

  always_comb begin
    case (reg_addr)
      A_OP:          reg_rdata = op_q;
      A_TXC:         reg_rdata = txc_q;
      A_RXC:         reg_rdata = rxc_q;
      A_STAT:        reg_rdata = status[7:0];
      A_STAT + 8'd1: reg_rdata = status[15:8];
      A_STAT + 8'd2: reg_rdata = status[23:16];
      A_STAT + 8'd3: reg_rdata = status[31:24];
      default:       reg_rdata = in_buf ? mem[boff[6:0]] : 8'h00;
    endcase
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int BUF_DEPTH = 71
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cs_n,
  input logic       sclk,
  input logic       we,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] op_q,
  input logic [7:0] txc,
  input logic [7:0] rxc,
  input logic [7:0] done
);
  logic [8:0] sum;
  logic       trig_req;
  assign sum      = {1'b0, txc} + {1'b0, rxc};
  assign trig_req = !busy && we && (addr == 8'h47) && wdata[7];

  assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_op_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(op_q));

  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && (sum > 9'(BUF_DEPTH))) |=> (!busy && cs_n));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && (sum <= 9'(BUF_DEPTH))) |=> (busy && !cs_n));

  assert_done_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ({1'b0, done} <= sum + 9'd1));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk),
  .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .op_q(op_q),
  .txc(txc_q), .rxc(rxc_q), .done(done_q)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int fails = 0;
  int gbit = 0;
  int rise_cnt = 0;
  int low_cnt = 0;
  int stray = 0;
  logic [7:0] resp [0:127];
  logic [7:0] cap [0:127];

  always #2.5 clk = ~clk;

  spi_cmd_engine u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  assign spi_miso = resp[(gbit / 8) % 128][7 - (gbit % 8)];

  always @(negedge spi_sclk) gbit = gbit + 1;
  always @(posedge spi_sclk) begin
    if (spi_cs_n) stray = stray + 1;
    cap[(rise_cnt / 8) % 128][7 - (rise_cnt % 8)] = spi_mosi;
    rise_cnt = rise_cnt + 1;
  end
  always @(negedge clk) if (!spi_cs_n) low_cnt = low_cnt + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(8'h4F, s);
      if (!s[7]) break;
    end
  endtask

  task automatic arm(input logic [7:0] op, input logic [7:0] tx, input logic [7:0] rx);
    wr(8'h45, op); wr(8'h48, tx); wr(8'h4B, rx);
    gbit = 0; rise_cnt = 0; low_cnt = 0; stray = 0;
  endtask

  task automatic check_status(input string req, input int done, input int wp, input int rp);
    logic [7:0] d;
    rd(8'h4C, d); check({req, " done"}, d, done);
    rd(8'h4D, d); check({req, " wr_ptr"}, d, wp);
    rd(8'h4E, d); check({req, " rd_ptr"}, d, rp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h4F, d); check("R6 reset status hi", d, 0);
    check_status("R6 reset", 0, 0, 0);
    check("R9 reset cs_n", spi_cs_n, 1);
    check("R9 reset sclk", spi_sclk, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(8'h45, 8'h3C); rd(8'h45, d); check("R1 opcode rb", d, 8'h3C);
    wr(8'h48, 8'h11); rd(8'h48, d); check("R1 txc rb", d, 8'h11);
    wr(8'h4B, 8'h22); rd(8'h4B, d); check("R1 rxc rb", d, 8'h22);
    wr(8'h80, 8'hA5); rd(8'h80, d); check("R1 buf0 rb", d, 8'hA5);
    wr(8'hC6, 8'h5C); rd(8'hC6, d); check("R1 buf70 rb", d, 8'h5C);
    wr(8'hC7, 8'h77); rd(8'hC7, d); check("R1 past buf", d, 0);
    rd(8'h47, d); check("R1 trigger reads 0", d, 0);
    rd(8'h46, d); check("R1 unused reads 0", d, 0);
  endtask

  task automatic t_read_only();
    logic [7:0] d;
    arm(8'h9F, 8'd0, 8'd3);
    wr(8'h47, 8'h80);
    wait_idle();
    check("R3 edges", rise_cnt, 32);
    check("R3 opcode first", cap[0], 8'h9F);
    for (int k = 1; k < 4; k++) check("R3 mosi zero in rx", cap[k], 0);
    for (int k = 0; k < 3; k++) begin
      rd(8'(8'h80 + k), d); check("R4 rx store", d, resp[1 + k]);
    end
    check_status("R6 after rx-only", 4, 3, 0);
    check("R9 cs low time", low_cnt, 8 * CLK_DIV * 4);
    check("R3 no edge with cs high", stray, 0);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    wr(8'h80, 8'hA1); wr(8'h81, 8'hB2); wr(8'h84, 8'h5A); wr(8'h85, 8'h66);
    arm(8'h03, 8'd2, 8'd2);
    wr(8'h47, 8'h80);
    rd(8'h4F, d); check("R5 busy set", d[7], 1);
    check("R3 cs low mid", spi_cs_n, 0);
    wr(8'h45, 8'hFF); wr(8'h48, 8'h09); wr(8'h85, 8'hEE);
    wr(8'h47, 8'h80);
    wait_idle();
    rd(8'h4F, d); check("R5 busy clear", d[7], 0);
    rd(8'h45, d); check("R8 opcode locked", d, 8'h03);
    rd(8'h48, d); check("R8 txc locked", d, 2);
    rd(8'h85, d); check("R8 buf locked", d, 8'h66);
    check("R8 retrigger ignored", low_cnt, 8 * CLK_DIV * 5);
    check("R3 edges", rise_cnt, 40);
    check("R3 opcode", cap[0], 8'h03);
    check("R3 tx0", cap[1], 8'hA1);
    check("R3 tx1", cap[2], 8'hB2);
    check("R3 rx mosi0", cap[3], 0);
    check("R3 rx mosi1", cap[4], 0);
    rd(8'h80, d); check("R4 tx kept", d, 8'hA1);
    rd(8'h82, d); check("R4 rx0 at txc", d, resp[3]);
    rd(8'h83, d); check("R4 rx1", d, resp[4]);
    rd(8'h84, d); check("R4 beyond untouched", d, 8'h5A);
    check_status("R6 after mixed", 5, 4, 2);
  endtask

  task automatic t_trig_bit0();
    logic [7:0] d;
    arm(8'h05, 8'd0, 8'd1);
    wr(8'h47, 8'h7F);
    repeat (20) @(negedge clk);
    rd(8'h4F, d); check("R2 bit7 clear no busy", d[7], 0);
    check("R2 bit7 clear no cs", low_cnt, 0);
  endtask

  task automatic t_reject();
    logic [7:0] d;
    arm(8'h0B, 8'd40, 8'd32);
    wr(8'h47, 8'h80);
    repeat (20) @(negedge clk);
    rd(8'h4F, d); check("R7 reject busy", d[7], 0);
    check("R7 reject cs", low_cnt, 0);
    check_status("R7 reject status kept", 5, 4, 2);
  endtask

  task automatic t_boundary();
    logic [7:0] d;
    wr(8'h80, 8'hC3);
    arm(8'h0B, 8'd1, 8'd70);
    wr(8'h47, 8'h80);
    wait_idle();
    check("R7 full size edges", rise_cnt, 8 * 72);
    check("R3 tx byte", cap[1], 8'hC3);
    rd(8'h81, d); check("R4 first rx", d, resp[2]);
    rd(8'hC6, d); check("R4 last rx", d, resp[71]);
    check_status("R6 full size", 72, 71, 1);
    check("R9 cs low full", low_cnt, 8 * CLK_DIV * 72);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) resp[i] = 8'((i * 37 + 11) & 8'hFF);
    for (int i = 0; i < 128; i++) cap[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_read_only();
    t_write_read();
    t_trig_bit0();
    t_reject();
    t_boundary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule